// File: doc/BRIEF.md
# I2C EEPROM Target

This block is a byte-wide serial memory that sits on a two-wire I2C bus as a target. A system clock oversamples the bus. Both lines pass through a synchroniser. The block detects START, repeated START and STOP, shifts address and data bytes in and out, and drives acknowledge bits through an open-drain pull-down enable. A controller writes a word address and then data bytes. It can follow the word address with a repeated START and a read command, which gives a random read. It can also issue a read command on its own, which continues from wherever the previous transfer left off.

The array is `MEM_BYTES` deep, 1024 by default. It occupies a window of `MEM_BYTES/256` consecutive 7-bit bus addresses that starts at an aligned `BASE_ADDR` (0x50 by default, so 0x50 to 0x53). The low bits of the bus address select the 256-byte bank, which forms the upper memory-address bits. The word-address byte replaces only the low eight bits. The memory address advances after every byte stored or sent and wraps at the array size. After reset the block sweeps the whole array to the erased value 0xFF. It stays silent on the bus until the sweep is finished.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset `sda_oe_o` is low and the current address is 0. Once the erase sweep has finished, every byte reads 0xFF.
- R2: An address byte whose upper five bits match `BASE_ADDR[6:2]` (0x50 to 0x53 by default) is acknowledged by pulling SDA low in the ninth clock. Any other bus address gets no acknowledge.
- R3: On a matching address byte, the current address bits [9:8] take the bus-address bits [1:0]. The first data byte after a write-direction address replaces only bits [7:0].
- R4: In the data bytes after the word address, each byte is acknowledged and stored at the current address, and the address then increments by one.
- R5: A read-direction address starts transmission, MSB first, of the byte at the current address. Each byte the controller acknowledges is followed by the next address.
- R6: Sequential writes and reads wrap from address 0x3FF to 0x000.
- R7: The current address survives a repeated START, so a word-address write followed by a repeated START with read returns data from that word address.
- R8: A controller NACK ends transmission and releases SDA without changing the transfer state. The next read command, with or without an intervening STOP, resumes at the address after the last byte sent.
- R9: A STOP returns the block to its idle state. Traffic for a bus address outside the window is not acknowledged, and it changes neither memory nor the current address.
- R10: The block changes its SDA pull-down only while SCL is low.
- R11: While the erase sweep is in progress the block acknowledges no address and never pulls SDA low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset; starts the erase sweep |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low; when low, SDA is released |

## Verification
The bench aims at the edges of the address arithmetic. One case is a write that runs from 0x3FE through the wrap to 0x000; a design with a wide counter or no wrap would put the third byte at 0x400 or in the wrong bank. Another is a write to one bank followed by a read of the same word address in another bank; a design that let the word byte clear the bank bits would alias the two. A further case is a read that the controller ends with NACK, followed by a bare read command. If the NACK reset the state or re-read the last byte, that second read returns the wrong byte. Addresses just outside the window (0x4F, 0x54) and an attempt to reach the block during its erase sweep check that it neither answers a foreign address nor drives SDA early.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

  // transfer-level state of the memory controller
  typedef enum logic [1:0] {
    XF_STOPPED,
    XF_ADDRESSING,
    XF_READING,
    XF_WRITING
  } xfer_state_e;

  // bit-level state of the serial engine
  typedef enum logic [2:0] {
    BE_IDLE,
    BE_RX,
    BE_ACK,
    BE_TX,
    BE_TXACK
  } bit_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_p;
  logic              sda_p;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_i};
          sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_o     = scl_q[STAGES-1];
  assign sda_o     = sda_q[STAGES-1];
  assign scl_rise  = scl_o & ~scl_p;
  assign scl_fall  = ~scl_o & scl_p;
  assign start_det = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_det  = scl_o & scl_p & ~sda_p & sda_o;

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_eeprom_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       rx_strobe,
  output logic [7:0] rx_byte,
  output logic       rx_is_addr,
  input  logic       ack_i,
  input  logic [7:0] tx_byte,
  output logic       tx_taken,
  output logic       tx_nack,
  output logic       sda_oe
);

  bit_state_e st;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic       addr_ph;
  logic       rd_dir;
  logic       ack_q;
  logic       mack;

  assign rx_byte    = shreg;
  assign rx_is_addr = addr_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= BE_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      addr_ph   <= 1'b0;
      rd_dir    <= 1'b0;
      ack_q     <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      rx_strobe <= 1'b0;
      tx_taken  <= 1'b0;
      tx_nack   <= 1'b0;
    end else begin
      rx_strobe <= 1'b0;
      tx_taken  <= 1'b0;
      tx_nack   <= 1'b0;
      // the decision is latched one cycle after the eighth bit, long before the fall
      if (rx_strobe) begin
        ack_q <= ack_i;
        if (addr_ph) rd_dir <= shreg[0];
      end
      if (start_det) begin
        st      <= BE_RX;
        cnt     <= '0;
        addr_ph <= 1'b1;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        st     <= BE_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          BE_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
              if (cnt == 4'd7) rx_strobe <= 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              sda_oe <= ack_q;
              st     <= ack_q ? BE_ACK : BE_IDLE;
            end
          end
          BE_ACK: begin
            if (scl_fall) begin
              addr_ph <= 1'b0;
              cnt     <= '0;
              if (addr_ph && rd_dir) begin
                shreg    <= tx_byte;
                sda_oe   <= ~tx_byte[7];
                tx_taken <= 1'b1;
                st       <= BE_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= BE_RX;
              end
            end
          end
          BE_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= BE_TXACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          BE_TXACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                shreg    <= tx_byte;
                sda_oe   <= ~tx_byte[7];
                tx_taken <= 1'b1;
                cnt      <= '0;
                st       <= BE_TX;
              end else begin
                tx_nack <= 1'b1;
                st      <= BE_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: the pull-down is only ever switched on during the low phase of SCL
  a_r10_pull_in_low_phase: assert property (@(posedge clk) disable iff (rst)
    (sda_oe && !$past(sda_oe)) |-> !scl_s);

  // R5: a loaded byte is always followed by a transmit phase
  a_r5_tx_after_load: assert property (@(posedge clk) disable iff (rst)
    (tx_taken && !start_det && !stop_det) |-> (st == BE_TX));

endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int         DEPTH  = 1024,
  parameter int         AW     = 10,
  parameter logic [7:0] ERASED = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] sweep;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b1;
      sweep <= '0;
    end else if (busy) begin
      sweep <= sweep + 1'b1;
      if (sweep == AW'(DEPTH - 1)) busy <= 1'b0;
    end
  end

  // single write port plus registered read port: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (busy) mem[sweep] <= ERASED;
    else if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  // R1: the erase sweep runs once per reset and never restarts on its own
  a_r1_sweep_once: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !busy);

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_eeprom_pkg::*;
#(
  parameter int         MEM_BYTES   = 1024,
  parameter logic [6:0] BASE_ADDR   = 7'h50,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ERASED      = 8'hFF
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  localparam int AW = $clog2(MEM_BYTES);
  localparam int WB = AW - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic rx_strobe, rx_is_addr, tx_taken, tx_nack, be_oe;
  logic [7:0] rx_byte, rd_data;
  logic ack_ok, busy, match, wr_en;
  logic [6:0] dev;
  logic [AW-1:0] cur_addr, addr_from_dev;
  xfer_state_e xstate;

  initial begin
    a_cfg_geometry: assert ((MEM_BYTES & (MEM_BYTES - 1)) == 0 && MEM_BYTES >= 256);
  end

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_engine u_engine (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rx_strobe(rx_strobe), .rx_byte(rx_byte), .rx_is_addr(rx_is_addr),
    .ack_i(ack_ok), .tx_byte(rd_data), .tx_taken(tx_taken),
    .tx_nack(tx_nack), .sda_oe(be_oe)
  );

  eeprom_array #(.DEPTH(MEM_BYTES), .AW(AW), .ERASED(ERASED)) u_array (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(cur_addr),
    .wr_data(rx_byte), .rd_addr(cur_addr), .rd_data(rd_data), .busy(busy)
  );

  assign sda_oe_o = be_oe;
  assign dev      = rx_byte[7:1];
  assign match    = (dev >> WB) == (BASE_ADDR >> WB);

  generate
    if (WB > 0) begin : g_bank
      assign addr_from_dev = {rx_byte[WB:1], cur_addr[7:0]};
    end else begin : g_flat
      assign addr_from_dev = cur_addr;
    end
  endgenerate

  always_comb begin
    if (busy) ack_ok = 1'b0;
    else if (rx_is_addr) ack_ok = match;
    else ack_ok = (xstate == XF_ADDRESSING) || (xstate == XF_WRITING);
  end

  assign wr_en = rx_strobe && ack_ok && !rx_is_addr && (xstate == XF_WRITING);

  always_ff @(posedge clk) begin
    if (rst) begin
      xstate   <= XF_STOPPED;
      cur_addr <= '0;
    end else if (stop_det) begin
      xstate <= XF_STOPPED;
    end else if (rx_strobe && ack_ok) begin
      if (rx_is_addr) begin
        xstate   <= rx_byte[0] ? XF_READING : XF_ADDRESSING;
        cur_addr <= addr_from_dev;
      end else if (xstate == XF_ADDRESSING) begin
        cur_addr[7:0] <= rx_byte;
        xstate        <= XF_WRITING;
      end else begin
        cur_addr <= cur_addr + 1'b1;
      end
    end else if (tx_taken) begin
      cur_addr <= cur_addr + 1'b1;
    end
  end

  // R4 and R6: a stored byte advances the address by one, wrapping at the array size
  a_r4_write_advance: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cur_addr == AW'($past(cur_addr) + 1'b1));

  // R5 and R6: every byte handed to the engine advances the address, with wrap
  a_r5_read_advance: assert property (@(posedge clk) disable iff (rst)
    (tx_taken && !stop_det) |=> cur_addr == AW'($past(cur_addr) + 1'b1));

  // R8: a controller NACK leaves the transfer state untouched
  a_r8_nack_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (tx_nack && !stop_det) |=> xstate == $past(xstate));

  // R9: STOP always lands in the idle state
  a_r9_stop_idles: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> xstate == XF_STOPPED);

  // R11: nothing is driven onto the bus while the array is being erased
  a_r11_quiet_while_erasing: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe_o);

  generate
    if (WB > 0) begin : g_bank_chk
      // R3: the bank bits come from the accepted bus address
      a_r3_bank_from_dev: assert property (@(posedge clk) disable iff (rst)
        (rx_strobe && rx_is_addr && ack_ok && !stop_det) |=>
          cur_addr[AW-1:8] == $past(rx_byte[WB:1]));
    end
  endgenerate

endmodule

// File: tb/i2c_eeprom_target_tb_top.sv
module i2c_eeprom_target_tb_top;

  localparam int         H    = 10;
  localparam logic [6:0] BASE = 7'h50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_eeprom_target dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  int ref_addr = 0;
  logic [7:0] ref_mem [1024];
  logic [7:0] wbuf [8];
  bit finished = 0;

  // R10 monitor: pull-down onsets seen while SCL was high throughout
  int viol = 0;
  int pulls = 0;
  logic scl_prev = 1'b1;
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && scl_m && scl_prev && sda_oe && !oe_prev) viol++;
    if (!rst && sda_oe && !oe_prev) pulls++;
    scl_prev = scl_m;
    oe_prev  = sda_oe;
  end

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit in_window(input logic [6:0] a);
    return a[6:2] == BASE[6:2];
  endfunction

  function automatic int bank_addr(input logic [6:0] a, input int cur);
    return (int'(a[1:0]) << 8) | (cur & 255);
  endfunction

  task automatic bus_start;
    sda_m = 1'b1; hw(H);
    scl_m = 1'b1; hw(H);
    sda_m = 1'b0; hw(H);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop;
    hw(2); sda_m = 1'b0; hw(H);
    scl_m = 1'b1; hw(H);
    sda_m = 1'b1; hw(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      hw(2); sda_m = b[i]; hw(H - 2);
      scl_m = 1'b1; hw(H);
      scl_m = 1'b0;
    end
    hw(2); sda_m = 1'b1; hw(H - 2);
    scl_m = 1'b1; hw(H / 2);
    acked = (sda_line == 1'b0);
    hw(H / 2);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      hw(H);
      scl_m = 1'b1; hw(H / 2);
      b[i] = sda_line;
      hw(H / 2);
      scl_m = 1'b0;
    end
    hw(2); sda_m = give_ack ? 1'b0 : 1'b1; hw(H - 2);
    scl_m = 1'b1; hw(H);
    scl_m = 1'b0;
    hw(2); sda_m = 1'b1;
  endtask

  task automatic addr_phase(input logic [6:0] a, input bit rd, input string tag);
    bit g;
    bit e;
    e = in_window(a);
    send_byte({a, rd}, g);
    check(g == e, tag, int'(g), int'(e));
    if (g) ref_addr = bank_addr(a, ref_addr);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] word, input int n, input string tag);
    bit g;
    bus_start;
    addr_phase(a, 1'b0, tag);
    send_byte(word, g);
    check(g, tag, int'(g), 1);
    ref_addr = (ref_addr & 'h300) | int'(word);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], g);
      check(g, tag, int'(g), 1);
      ref_mem[ref_addr] = wbuf[i];
      ref_addr = (ref_addr + 1) % 1024;
    end
    bus_stop;
  endtask

  task automatic do_read(input logic [6:0] a, input bit set_word, input logic [7:0] word,
                         input int n, input bit stop_after, input string tag);
    bit g;
    logic [7:0] d;
    if (set_word) begin
      bus_start;
      addr_phase(a, 1'b0, tag);
      send_byte(word, g);
      check(g, tag, int'(g), 1);
      ref_addr = (ref_addr & 'h300) | int'(word);
    end
    bus_start;
    addr_phase(a, 1'b1, tag);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      check(d == ref_mem[ref_addr], tag, int'(d), int'(ref_mem[ref_addr]));
      ref_addr = (ref_addr + 1) % 1024;
    end
    if (stop_after) bus_stop;
  endtask

  task automatic finish_run;
    check(viol == 0, "R10 pull-down onset during SCL high", viol, 0);
    check(pulls > 0, "R10 pull-down observed", pulls, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    finished = 1;
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit g;
    void'($urandom(32'h5EED_1C2E));
    for (int i = 0; i < 1024; i++) ref_mem[i] = 8'hFF;
    hw(5);
    check(sda_oe == 1'b0, "R1 released in reset", int'(sda_oe), 0);
    rst = 1'b0;
    hw(1);
    check(sda_oe == 1'b0, "R1 released after reset", int'(sda_oe), 0);

    // R11: address attempt while erasing is refused
    bus_start;
    send_byte({BASE, 1'b0}, g);
    check(!g, "R11 no ack during erase", int'(g), 0);
    bus_stop;
    hw(1200);

    // R1: current-address read from 0 returns erased bytes
    do_read(BASE, 1'b0, 8'h00, 2, 1'b1, "R1 erased read at 0");
    do_read(BASE | 7'd2, 1'b1, 8'h77, 2, 1'b1, "R1 erased read in bank 2");

    // R2: window edges
    do_read(BASE | 7'd3, 1'b0, 8'h00, 1, 1'b1, "R2 top of window acks");
    bus_start; addr_phase(7'h4F, 1'b0, "R2 below window nack"); bus_stop;
    bus_start; addr_phase(7'h54, 1'b0, "R2 above window nack"); bus_stop;
    bus_start; addr_phase(7'h58, 1'b1, "R2 far address nack"); bus_stop;

    // R3 and R4: write into bank 1, then read it and the same word in bank 0
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    do_write(BASE | 7'd1, 8'h20, 4, "R4 sequential write bank 1");
    do_read(BASE | 7'd1, 1'b1, 8'h20, 4, 1'b1, "R7 R3 random read bank 1");
    do_read(BASE, 1'b1, 8'h20, 2, 1'b1, "R3 bank 0 unaffected");

    // R6: write and read across the wrap point
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(BASE | 7'd3, 8'hFE, 3, "R6 write wrap");
    do_read(BASE | 7'd3, 1'b1, 8'hFE, 3, 1'b1, "R6 read wrap");
    do_read(BASE, 1'b1, 8'h00, 1, 1'b1, "R6 wrapped byte at 0");

    // R8: NACK then resume, with and without STOP
    do_read(BASE | 7'd1, 1'b1, 8'h20, 2, 1'b1, "R8 read ended by nack");
    do_read(BASE | 7'd1, 1'b0, 8'h00, 1, 1'b0, "R8 resume after stop");
    do_read(BASE | 7'd1, 1'b0, 8'h00, 1, 1'b1, "R8 resume after repeated start");

    // R9: foreign traffic ignored, memory and address unchanged
    bus_start;
    addr_phase(7'h30, 1'b0, "R9 foreign address nack");
    send_byte(8'h21, g);
    check(!g, "R9 foreign data nack", int'(g), 0);
    bus_stop;
    do_read(BASE | 7'd1, 1'b0, 8'h00, 1, 1'b1, "R9 address kept after foreign traffic");
    do_read(BASE | 7'd1, 1'b1, 8'h20, 4, 1'b1, "R9 memory kept after foreign traffic");

    // random mix of writes and reads against the model
    for (int it = 0; it < 14; it++) begin
      logic [6:0] a;
      int n;
      a = BASE | 7'($urandom_range(0, 3));
      n = $urandom_range(1, 6);
      for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
      do_write(a, 8'($urandom), n, "R4 random write");
      a = BASE | 7'($urandom_range(0, 3));
      do_read(a, ($urandom_range(0, 3) != 0), 8'($urandom), $urandom_range(1, 5),
              ($urandom_range(0, 1) == 1), "R5 random read");
    end
    bus_stop;
    finish_run;
  end

endmodule